// File: doc/BRIEF.md
# Prioritised Memory Region Permission Checker

This block decides whether a single memory access may go ahead. It takes a bank of protection entries. Each entry is a configuration byte plus an address word that holds a byte address shifted right by two. From these, each entry is turned into an inclusive byte range, using one of three matching styles: top-of-range, naturally aligned four bytes, or naturally aligned power of two.

Each access has an address, a size, a requested read/write/execute mask and a machine-mode flag. The block compares the first and last byte of the access against every range at once. The lowest-numbered entry that touches the access decides the result. An access that only partly falls inside that entry is flagged as a violation and is never granted.

Two security controls change how permissions are resolved. A lockdown control replaces the plain permission bits with fixed lookup tables, one for machine mode and one for other modes. A deny-default control refuses every access that no entry matches. The result is registered: the allowed mask, the deciding entry index, a default-used flag, a violation flag and a final grant appear one clock after the inputs are presented.

Top module: `region_guard`

## Requirements
- R1: Configuration byte layout is: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 match style (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), bit 7 lock. Bits 6:5 are ignored. An entry whose style is off never matches.
- R2: A four-byte entry covers byte addresses word*4 through word*4+3.
- R3: A top-of-range entry i covers byte addresses prev*4 through word*4-1, where prev is the address word of entry i-1, and entry 0 uses prev = 0. If the start lies above the end, the range shrinks to the single byte 0.
- R4: For a power-of-two entry, form a = word*4+3. The entry covers a AND (a+1) through a OR (a+1), computed at the full byte-address width.
- R5: An access covers bytes addr through addr + 2^size - 1, where acc_size_i = 0, 1, 2, 3 means 1, 2, 4, 8 bytes.
- R6: The lowest-numbered entry holding both the first and the last byte decides the result, and hit_idx_o reports its number.
- R7: If the lowest-numbered entry that holds either end byte holds only one of them, the result is as follows: straddle_o is 1, hit_idx_o is that entry, allow_o is 0 and grant_o is 0. Higher-numbered entries are not consulted.
- R8: With lockdown off, a deciding entry allows its own R/W/X bits. The exception is a machine-mode access to an entry whose lock bit is clear, which gets R/W/X all allowed.
- R9: With lockdown on and machine mode, take the 4-bit index {lock,R,W,X} of the deciding entry. Index 2, 3 or 14 allows RW. Index 9 or 10 allows X. Index 11 or 13 allows RX. Index 12 or 15 allows R. Every other index allows nothing.
- R10: With lockdown on and another mode, index 1, 10 or 11 allows X. Index 2, 4 or 15 allows R. Index 3 or 6 allows RW. Index 5 allows RX. Index 7 allows RWX. Every other index allows nothing.
- R11: When nothing matches, hit_default_o is 1 and hit_idx_o equals the entry count. Deny-default then allows nothing. Otherwise, if lockdown is on, a machine-mode request without execute gets RW and anything else gets nothing. Otherwise, machine mode gets RWX and other modes get nothing.
- R12: grant_o is 1 exactly when there is no violation and every requested bit is also an allowed bit. The mask bit order is bit 0 R, bit 1 W, bit 2 X.
- R13: All outputs are registered with one cycle of latency. A synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_cfg_i | input | ENTRIES*8 | Configuration bytes; entry i at bits [8i+7:8i] |
| ent_addr_i | input | ENTRIES*(PA_W-2) | Address words (byte address >> 2); entry i at slice i |
| lockdown_i | input | 1 | Select table-based permission resolution |
| deny_default_i | input | 1 | Refuse every access that matches no entry |
| acc_addr_i | input | PA_W | Byte address of the access |
| acc_size_i | input | 2 | Log2 of the access size in bytes |
| acc_req_i | input | 3 | Requested permissions {X,W,R} |
| acc_mmode_i | input | 1 | Access is made in machine mode |
| allow_o | output | 3 | Allowed permissions {X,W,R} |
| hit_idx_o | output | $clog2(ENTRIES)+1 | Deciding entry, or ENTRIES when none matched |
| hit_default_o | output | 1 | No entry matched; default policy applied |
| straddle_o | output | 1 | Access only partly inside the deciding entry |
| grant_o | output | 1 | Access permitted |

## Verification
The bench builds the checker with four entries and a 34-bit byte address. With only four entries, one fixed layout can hold a four-byte, a top-of-range, a locked power-of-two and a wide low-priority power-of-two entry, all overlapping. That makes priority, straddles that stop the scan, and fall-through to defaults all reachable from short vectors. The full address width keeps the all-ones power-of-two encoding and upper-half addresses in play. Because entry 0 is simply rewritten for each of the sixteen {lock,R,W,X} codes, both lockdown tables can be swept completely.

// File: rtl/rgnchk_pkg.sv
package rgnchk_pkg;

  typedef enum logic [1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_TOR   = 2'd1,
    MATCH_NA4   = 2'd2,
    MATCH_NAPOT = 2'd3
  } match_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    match_e     mode;
    logic       x;
    logic       w;
    logic       r;
  } ent_cfg_t;

  // permission masks, bit order {X,W,R}
  localparam logic [2:0] PERM_NONE = 3'b000;
  localparam logic [2:0] PERM_R    = 3'b001;
  localparam logic [2:0] PERM_RW   = 3'b011;
  localparam logic [2:0] PERM_X    = 3'b100;
  localparam logic [2:0] PERM_RX   = 3'b101;
  localparam logic [2:0] PERM_RWX  = 3'b111;

  // lockdown table for machine-mode accesses, index {lock,R,W,X}
  function automatic logic [2:0] lock_tbl_mach(input logic [3:0] ix);
    case (ix)
      4'd2, 4'd3, 4'd14: lock_tbl_mach = PERM_RW;
      4'd9, 4'd10:       lock_tbl_mach = PERM_X;
      4'd11, 4'd13:      lock_tbl_mach = PERM_RX;
      4'd12, 4'd15:      lock_tbl_mach = PERM_R;
      default:           lock_tbl_mach = PERM_NONE;
    endcase
  endfunction

  // lockdown table for every other mode
  function automatic logic [2:0] lock_tbl_user(input logic [3:0] ix);
    case (ix)
      4'd1, 4'd10, 4'd11: lock_tbl_user = PERM_X;
      4'd2, 4'd4, 4'd15:  lock_tbl_user = PERM_R;
      4'd3, 4'd6:         lock_tbl_user = PERM_RW;
      4'd5:               lock_tbl_user = PERM_RX;
      4'd7:               lock_tbl_user = PERM_RWX;
      default:            lock_tbl_user = PERM_NONE;
    endcase
  endfunction

endpackage

// File: rtl/rgnchk_range.sv
module rgnchk_range
  import rgnchk_pkg::*;
#(
  parameter int PA_W = 34
) (
  input  logic            clk,
  input  logic            rst,
  input  match_e          mode,
  input  logic [PA_W-3:0] cur_addr,
  input  logic [PA_W-3:0] prev_addr,
  input  logic [PA_W-1:0] first,
  input  logic [PA_W-1:0] last,
  output logic            in_first,
  output logic            in_last
);

  logic [PA_W-1:0] lo;
  logic [PA_W-1:0] hi;
  logic [PA_W-1:0] cur_b;
  logic [PA_W-1:0] prev_b;
  logic [PA_W-1:0] napot_a;
  logic [PA_W-1:0] napot_inc;
  logic            active;

  assign cur_b     = {cur_addr, 2'b00};
  assign prev_b    = {prev_addr, 2'b00};
  assign napot_a   = {cur_addr, 2'b11};
  assign napot_inc = napot_a + {{(PA_W-1){1'b0}}, 1'b1};
  assign active    = (mode != MATCH_OFF);

  always_comb begin
    lo = '0;
    hi = '1;
    case (mode)
      MATCH_TOR: begin
        lo = prev_b;
        hi = cur_b - {{(PA_W-1){1'b0}}, 1'b1};
        if (lo > hi) begin
          lo = '0;
          hi = '0;
        end
      end
      MATCH_NA4: begin
        lo = cur_b;
        hi = cur_b | {{(PA_W-2){1'b0}}, 2'b11};
      end
      MATCH_NAPOT: begin
        lo = napot_a & napot_inc;
        hi = napot_a | napot_inc;
      end
      default: begin
        lo = '0;
        hi = '1;
      end
    endcase
  end

  assign in_first = active && (first >= lo) && (first <= hi);
  assign in_last  = active && (last >= lo) && (last <= hi);

  assert_na4_span_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == MATCH_NA4) |-> ((hi - lo) == {{(PA_W-2){1'b0}}, 2'b11}));

  assert_napot_order_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == MATCH_NAPOT) |-> (lo <= hi));

  assert_tor_order_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == MATCH_TOR) |-> (lo <= hi));

endmodule

// File: rtl/rgnchk_scan.sv
module rgnchk_scan #(
  parameter int ENTRIES = 16,
  parameter int IDXW    = 5
) (
  input  logic [ENTRIES-1:0] in_first,
  input  logic [ENTRIES-1:0] in_last,
  output logic               hit,
  output logic               straddle,
  output logic [IDXW-1:0]    idx
);

  // walk from the top so the lowest touching entry is assigned last
  always_comb begin
    hit      = 1'b0;
    straddle = 1'b0;
    idx      = IDXW'(ENTRIES);
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (in_first[i] || in_last[i]) begin
        hit      = in_first[i] && in_last[i];
        straddle = in_first[i] ^ in_last[i];
        idx      = IDXW'(i);
      end
    end
  end

endmodule

// File: rtl/rgnchk_perm.sv
module rgnchk_perm
  import rgnchk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     lockdown,
  input  logic     deny_default,
  input  logic     mmode,
  input  logic     req_x,
  input  logic     hit,
  input  logic     straddle,
  input  ent_cfg_t cfg,
  output logic [2:0] allow
);

  logic [3:0] tbl_ix;
  logic [2:0] own_bits;

  assign tbl_ix   = {cfg.lock, cfg.r, cfg.w, cfg.x};
  assign own_bits = {cfg.x, cfg.w, cfg.r};

  always_comb begin
    allow = PERM_NONE;
    if (straddle) begin
      allow = PERM_NONE;
    end else if (hit) begin
      if (!lockdown) begin
        allow = (mmode && !cfg.lock) ? PERM_RWX : own_bits;
      end else if (mmode) begin
        allow = lock_tbl_mach(tbl_ix);
      end else begin
        allow = lock_tbl_user(tbl_ix);
      end
    end else if (deny_default) begin
      allow = PERM_NONE;
    end else if (lockdown) begin
      allow = (mmode && !req_x) ? PERM_RW : PERM_NONE;
    end else begin
      allow = mmode ? PERM_RWX : PERM_NONE;
    end
  end

  assert_lock_mach_no_rwx_R9: assert property (@(posedge clk) disable iff (rst)
    (lockdown && mmode && hit) |-> (allow != PERM_RWX));

  assert_lock_user_no_wonly_R10: assert property (@(posedge clk) disable iff (rst)
    (lockdown && !mmode && hit) |-> (allow != 3'b010));

endmodule

// File: rtl/region_guard.sv
module region_guard
  import rgnchk_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PA_W    = 34
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ENTRIES*8-1:0]          ent_cfg_i,
  input  logic [ENTRIES*(PA_W-2)-1:0]   ent_addr_i,
  input  logic                          lockdown_i,
  input  logic                          deny_default_i,
  input  logic [PA_W-1:0]               acc_addr_i,
  input  logic [1:0]                    acc_size_i,
  input  logic [2:0]                    acc_req_i,
  input  logic                          acc_mmode_i,
  output logic [2:0]                    allow_o,
  output logic [$clog2(ENTRIES):0]      hit_idx_o,
  output logic                          hit_default_o,
  output logic                          straddle_o,
  output logic                          grant_o
);

  localparam int AW   = PA_W - 2;
  localparam int IDXW = $clog2(ENTRIES) + 1;

  ent_cfg_t          cfg_a  [ENTRIES];
  logic [AW-1:0]     addr_a [ENTRIES];
  logic [ENTRIES-1:0] in_first;
  logic [ENTRIES-1:0] in_last;
  logic [PA_W-1:0]   first_b;
  logic [PA_W-1:0]   last_b;
  logic [PA_W-1:0]   span_m1;
  logic              hit_c;
  logic              straddle_c;
  logic [IDXW-1:0]   idx_c;
  ent_cfg_t          cfg_sel;
  logic [2:0]        allow_c;
  logic              grant_c;

  assign span_m1 = PA_W'((4'd1 << acc_size_i) - 4'd1);
  assign first_b = acc_addr_i;
  assign last_b  = acc_addr_i + span_m1;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [AW-1:0] prev_w;
    assign cfg_a[g]  = ent_cfg_t'(ent_cfg_i[g*8 +: 8]);
    assign addr_a[g] = ent_addr_i[g*AW +: AW];
    if (g == 0) begin : g_first
      assign prev_w = '0;
    end else begin : g_rest
      assign prev_w = ent_addr_i[(g-1)*AW +: AW];
    end
    rgnchk_range #(.PA_W(PA_W)) u_rng (
      .clk      (clk),
      .rst      (rst),
      .mode     (cfg_a[g].mode),
      .cur_addr (addr_a[g]),
      .prev_addr(prev_w),
      .first    (first_b),
      .last     (last_b),
      .in_first (in_first[g]),
      .in_last  (in_last[g])
    );
  end

  rgnchk_scan #(.ENTRIES(ENTRIES), .IDXW(IDXW)) u_scan (
    .in_first(in_first),
    .in_last (in_last),
    .hit     (hit_c),
    .straddle(straddle_c),
    .idx     (idx_c)
  );

  always_comb begin
    cfg_sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (idx_c == IDXW'(i)) cfg_sel = cfg_a[i];
    end
  end

  rgnchk_perm u_perm (
    .clk         (clk),
    .rst         (rst),
    .lockdown    (lockdown_i),
    .deny_default(deny_default_i),
    .mmode       (acc_mmode_i),
    .req_x       (acc_req_i[2]),
    .hit         (hit_c),
    .straddle    (straddle_c),
    .cfg         (cfg_sel),
    .allow       (allow_c)
  );

  assign grant_c = !straddle_c && ((acc_req_i & ~allow_c) == 3'b000);

  always_ff @(posedge clk) begin
    if (rst) begin
      allow_o       <= '0;
      hit_idx_o     <= '0;
      hit_default_o <= 1'b0;
      straddle_o    <= 1'b0;
      grant_o       <= 1'b0;
    end else begin
      allow_o       <= allow_c;
      hit_idx_o     <= idx_c;
      hit_default_o <= !hit_c && !straddle_c;
      straddle_o    <= straddle_c;
      grant_o       <= grant_c;
    end
  end

  assert_grant_subset_R12: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> (($past(acc_req_i) & ~allow_o) == 3'b000));

  assert_straddle_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    straddle_o |-> (!grant_o && (allow_o == 3'b000) && !hit_default_o));

  assert_default_index_R11: assert property (@(posedge clk) disable iff (rst)
    hit_default_o |-> (hit_idx_o == IDXW'(ENTRIES)));

  assert_deny_default_R11: assert property (@(posedge clk) disable iff (rst)
    (hit_default_o && $past(deny_default_i)) |-> (allow_o == 3'b000));

  assert_reset_clear_R13: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!grant_o && !hit_default_o && !straddle_o && (allow_o == 3'b000)));

endmodule

// File: tb/region_guard_test.sv
`timescale 1ns/1ps
module region_guard_test;

  localparam int ENTRIES = 4;
  localparam int PA_W    = 34;
  localparam int AW      = PA_W - 2;
  localparam int IDXW    = $clog2(ENTRIES) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [7:0]      c [ENTRIES];
  logic [AW-1:0]   a [ENTRIES];
  logic [ENTRIES*8-1:0]  ent_cfg;
  logic [ENTRIES*AW-1:0] ent_addr;
  logic            lk, wp, mm;
  logic [PA_W-1:0] ad;
  logic [1:0]      sz;
  logic [2:0]      rq;
  logic [2:0]      allow;
  logic [IDXW-1:0] idx;
  logic            dflt, strd, grant;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      ent_cfg[i*8 +: 8]   = c[i];
      ent_addr[i*AW +: AW] = a[i];
    end
  end

  region_guard #(.ENTRIES(ENTRIES), .PA_W(PA_W)) uut (
    .clk(clk), .rst(rst), .ent_cfg_i(ent_cfg), .ent_addr_i(ent_addr),
    .lockdown_i(lk), .deny_default_i(wp), .acc_addr_i(ad), .acc_size_i(sz),
    .acc_req_i(rq), .acc_mmode_i(mm), .allow_o(allow), .hit_idx_o(idx),
    .hit_default_o(dflt), .straddle_o(strd), .grant_o(grant)
  );

  int n_chk = 0;
  int n_bad = 0;

  typedef struct packed {
    logic [15:0] tg;
    logic        lk;
    logic        wp;
    logic        mm;
    logic [1:0]  sz;
    logic [2:0]  rq;
    logic [31:0] ad;
    logic [2:0]  ea;
    logic [2:0]  ei;
    logic        ed;
    logic        es;
    logic        eg;
  } vec_t;

  localparam int NV = 25;
  // base layout: e0 NA4 0x100 R; e1 TOR 0x100..0x1FF RW; e2 locked NAPOT 0x1000..0x1FFF RX; e3 NAPOT 0..0xFFFF X
  localparam vec_t VECS [NV] = '{
    '{"R2", 0,0,0,2'd2,3'b001,32'h100,   3'b001,3'd0,0,0,1},
    '{"R8", 0,0,0,2'd2,3'b010,32'h100,   3'b001,3'd0,0,0,0},
    '{"R7", 0,0,0,2'd2,3'b001,32'h102,   3'b000,3'd0,0,1,0},
    '{"R5", 0,0,0,2'd3,3'b011,32'h104,   3'b011,3'd1,0,0,1},
    '{"R7", 0,0,0,2'd3,3'b001,32'h1FC,   3'b000,3'd1,0,1,0},
    '{"R4", 0,0,0,2'd1,3'b100,32'h1800,  3'b101,3'd2,0,0,1},
    '{"R8", 0,0,1,2'd1,3'b010,32'h1800,  3'b101,3'd2,0,0,0},
    '{"R8", 0,0,1,2'd0,3'b100,32'h104,   3'b111,3'd1,0,0,1},
    '{"R6", 0,0,0,2'd0,3'b100,32'h300,   3'b100,3'd3,0,0,1},
    '{"R11",0,0,0,2'd2,3'b001,32'h20000, 3'b000,3'd4,1,0,0},
    '{"R11",0,0,1,2'd2,3'b111,32'h20000, 3'b111,3'd4,1,0,1},
    '{"R11",0,1,1,2'd2,3'b001,32'h20000, 3'b000,3'd4,1,0,0},
    '{"R11",1,0,1,2'd2,3'b011,32'h20000, 3'b011,3'd4,1,0,1},
    '{"R11",1,0,1,2'd2,3'b100,32'h20000, 3'b000,3'd4,1,0,0},
    '{"R11",1,0,0,2'd2,3'b001,32'h20000, 3'b000,3'd4,1,0,0},
    '{"R9", 1,0,1,2'd0,3'b001,32'h100,   3'b000,3'd0,0,0,0},
    '{"R10",1,0,0,2'd0,3'b001,32'h100,   3'b001,3'd0,0,0,1},
    '{"R9", 1,0,1,2'd0,3'b100,32'h1800,  3'b101,3'd2,0,0,1},
    '{"R10",1,0,0,2'd0,3'b100,32'h1800,  3'b000,3'd2,0,0,0},
    '{"R10",1,0,0,2'd0,3'b011,32'h104,   3'b011,3'd1,0,0,1},
    '{"R10",1,0,0,2'd0,3'b100,32'h300,   3'b100,3'd3,0,0,1},
    '{"R9", 1,0,1,2'd0,3'b100,32'h300,   3'b000,3'd3,0,0,0},
    '{"R7", 0,0,0,2'd2,3'b001,32'h1FFE,  3'b000,3'd2,0,1,0},
    '{"R3", 0,0,0,2'd0,3'b011,32'h1FF,   3'b011,3'd1,0,0,1},
    '{"R12",0,0,0,2'd0,3'b001,32'h200,   3'b100,3'd3,0,0,0}
  };

  task automatic base_cfg();
    c[0] = 8'h11; a[0] = 32'h40;
    c[1] = 8'h0B; a[1] = 32'h80;
    c[2] = 8'h9D; a[2] = 32'h5FF;
    c[3] = 8'h1C; a[3] = 32'h1FFF;
  endtask

  task automatic apply(input logic l, input logic w, input logic m, input logic [1:0] s,
                       input logic [2:0] r, input logic [PA_W-1:0] adr);
    @(negedge clk);
    lk = l; wp = w; mm = m; sz = s; rq = r; ad = adr;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b (allow,idx,default,straddle,grant)", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_lock(input logic m, input logic [3:0] ix);
    if (m) begin
      case (ix)
        4'd2, 4'd3, 4'd14: return 3'b011;
        4'd9, 4'd10:       return 3'b100;
        4'd11, 4'd13:      return 3'b101;
        4'd12, 4'd15:      return 3'b001;
        default:           return 3'b000;
      endcase
    end else begin
      case (ix)
        4'd1, 4'd10, 4'd11: return 3'b100;
        4'd2, 4'd4, 4'd15:  return 3'b001;
        4'd3, 4'd6:         return 3'b011;
        4'd5:               return 3'b101;
        4'd7:               return 3'b111;
        default:            return 3'b000;
      endcase
    end
  endfunction

  function automatic logic [10:0] outs();
    return {allow, 3'(idx), dflt, strd, grant};
  endfunction

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL R13 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    base_cfg();
    lk = 0; wp = 0; mm = 0; sz = 0; rq = 0; ad = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R13 reset", outs(), 11'b0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      apply(VECS[v].lk, VECS[v].wp, VECS[v].mm, VECS[v].sz, VECS[v].rq, PA_W'(VECS[v].ad));
      check($sformatf("%s vec%0d", VECS[v].tg, v), outs(),
            {VECS[v].ea, VECS[v].ei, VECS[v].ed, VECS[v].es, VECS[v].eg});
    end

    // R3: inverted top-of-range collapses to byte 0
    c[0] = 8'h11; a[0] = 32'h80; a[1] = 32'h40;
    apply(0, 0, 0, 2'd0, 3'b001, 34'h0);
    check("R3 collapse hit", outs(), {3'b011, 3'd1, 1'b0, 1'b0, 1'b1});
    apply(0, 0, 0, 2'd0, 3'b100, 34'h1);
    check("R3 collapse miss", outs(), {3'b100, 3'd3, 1'b0, 1'b0, 1'b1});
    apply(0, 0, 0, 2'd1, 3'b001, 34'h0);
    check("R3 collapse straddle", outs(), {3'b000, 3'd1, 1'b0, 1'b1, 1'b0});

    // R3: entry 0 top-of-range starts at byte 0
    base_cfg();
    c[0] = 8'h09; a[0] = 32'h10;
    apply(0, 0, 0, 2'd2, 3'b001, 34'h3C);
    check("R3 entry0 tor", outs(), {3'b001, 3'd0, 1'b0, 1'b0, 1'b1});
    apply(0, 0, 0, 2'd2, 3'b001, 34'h3E);
    check("R3 entry0 tor edge", outs(), {3'b000, 3'd0, 1'b0, 1'b1, 1'b0});

    // R1: off entry skipped, reserved bits ignored
    base_cfg();
    c[0] = 8'h00;
    apply(0, 0, 0, 2'd0, 3'b001, 34'h100);
    check("R1 off skipped", outs(), {3'b011, 3'd1, 1'b0, 1'b0, 1'b1});
    c[0] = 8'h71;
    apply(0, 0, 0, 2'd0, 3'b011, 34'h100);
    check("R1 reserved ignored", outs(), {3'b001, 3'd0, 1'b0, 1'b0, 1'b0});

    // R4: all-ones power-of-two word covers the whole space
    c[0] = 8'h19; a[0] = 32'hFFFF_FFFF;
    apply(0, 0, 0, 2'd3, 3'b001, 34'h3_FFFF_FFF8);
    check("R4 napot all ones", outs(), {3'b001, 3'd0, 1'b0, 1'b0, 1'b1});

    // R9 / R10: full lockdown table sweep on entry 0
    base_cfg();
    for (int ix = 0; ix < 16; ix++) begin
      logic [3:0] b;
      b = 4'(ix);
      c[0] = {b[3], 2'b00, 2'b10, b[0], b[1], b[2]};
      apply(1, 0, 1, 2'd0, 3'b000, 34'h100);
      check($sformatf("R9 idx%0d", ix), outs(), {exp_lock(1'b1, b), 3'd0, 1'b0, 1'b0, 1'b1});
      apply(1, 0, 0, 2'd0, 3'b000, 34'h100);
      check($sformatf("R10 idx%0d", ix), outs(), {exp_lock(1'b0, b), 3'd0, 1'b0, 1'b0, 1'b1});
    end

    // R13: reset mid-stream clears registered outputs
    base_cfg();
    apply(0, 0, 1, 2'd2, 3'b111, 34'h20000);
    check("R11 pre-reset grant", outs(), {3'b111, 3'd4, 1'b1, 1'b0, 1'b1});
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R13 reset clears", outs(), 11'b0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule